// File: doc/BRIEF.md
# Column-Bypassing Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Partial products are summed in a carry-save grid of full-adder cells. A ripple-carry row at the bottom resolves the carries that are still pending. Each grid cell is steered by one multiplicand bit. When that bit is zero, the cell's adder inputs are forced low by AND gates, and a mux passes the sum arriving from the cell above straight down. The carry leaving that cell stays at zero.

The arithmetic is combinational. A register stage can be enabled on the operand side, on the product side, or on both, so the block fits into a pipeline of any depth from zero to two. The operand width is a parameter with a default of 4.

There is no state machine. The only sequential elements are the optional stage registers. Each stage has two conditions: while reset is held it reads zero; once reset is released it passes data through.

Top module: `col_bypass_mult`

## Requirements
- R1: With N=4, `product` equals `mcand * mplier` as an unsigned 8-bit value for all 256 operand pairs.
- R2: If the multiplicand is 0, the product is 0. A multiplicand with zero bits interleaved, 4'b1010 times 4'b1111, still gives exactly 150 (8'h96).
- R3: All-ones operands give (2^N-1)^2. That is 225 (8'hE1) for N=4 and 65025 (16'hFE01) for N=8.
- R4: A grid cell whose multiplicand bit is 0 emits no carry. A one-hot multiplicand 2^k therefore gives the multiplicator shifted left by k bits.
- R5: A multiplicator of 0 gives a product of 0. A multiplicator of 1 gives the multiplicand, zero-extended.
- R6: The product appears IN_REG+OUT_REG rising clock edges after the operands are applied. With both parameters set to 1, the previous product stays on the output until the second edge.
- R7: With IN_REG=0 and OUT_REG=0, `product` follows the operands with no clock edge.
- R8: While `rst_n` is low, every enabled register stage holds zero, so a fully registered instance shows a product of 0.
- R9: With N=8, the 16-bit product is exact for random operand pairs and for edge values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Active-low asynchronous reset that clears the stage registers |
| mcand | input | N | Multiplicand; its bits select bypass per grid column |
| mplier | input | N | Multiplicator |
| product | output | 2N | Unsigned product |

## Verification
The fully registered instance (N=4) is due to show each result two rising edges after its operands change. Operands are driven on a falling edge, and the output is sampled on the second falling edge after that. The latency scenario also samples the falling edge between the two rising edges and expects the older product there. The combinational instance (N=8) is driven on a falling edge and sampled one nanosecond later, well before the next rising edge. The reset check samples while reset is still asserted, after operands have been presented for several edges.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } fa_res_t;

    function automatic fa_res_t full_add(input logic x, input logic y, input logic z);
        fa_res_t r;
        r.s = x ^ y ^ z;
        r.c = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/cbm_cell.sv
module cbm_cell
    import cbm_pkg::*;
(
    input  logic sel,
    input  logic pp,
    input  logic s_up,
    input  logic c_up,
    output logic s_dn,
    output logic c_dn
);

    fa_res_t add_r;

    always_comb begin
        // inputs gated by the column's multiplicand bit
        add_r = full_add(pp & sel, s_up & sel, c_up & sel);
        s_dn  = sel ? add_r.s : s_up;
        c_dn  = add_r.c;
    end

endmodule

// File: rtl/cbm_ripple.sv
module cbm_ripple
    import cbm_pkg::*;
#(
    parameter int W = 3
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] rc;
    assign rc[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : g_bit
        fa_res_t r;
        always_comb r = full_add(x[j], y[j], rc[j]);
        assign sum[j]  = r.s;
        assign rc[j+1] = r.c;
    end

    assign cout = rc[W];

endmodule

// File: rtl/cbm_stage.sv
module cbm_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    if (EN) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_pass
        assign q = d;
    end

    // R6: a stage adds exactly one edge when enabled, none otherwise
    p_stage_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (q == (EN ? $past(d) : d)));

endmodule

// File: rtl/cbm_array.sv
module cbm_array #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] prod
);

    localparam int ROWS  = N - 1;
    localparam int CELLS = N - 1;

    logic [CELLS-1:0] s_row [1:ROWS];
    logic [CELLS-1:0] c_row [1:ROWS];

    for (genvar r = 1; r <= ROWS; r++) begin : g_row
        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            logic s_in, c_in;
            if (r == 1) begin : g_first
                assign s_in = a[i+1] & b[0];
                assign c_in = 1'b0;
            end else if (i == CELLS - 1) begin : g_edge
                assign s_in = a[N-1] & b[r-1];
                assign c_in = c_row[r-1][i];
            end else begin : g_mid
                assign s_in = s_row[r-1][i+1];
                assign c_in = c_row[r-1][i];
            end

            cbm_cell u_cell (
                .sel  (a[i]),
                .pp   (a[i] & b[r]),
                .s_up (s_in),
                .c_up (c_in),
                .s_dn (s_row[r][i]),
                .c_dn (c_row[r][i])
            );

            // R4: a bypassed column carries nothing downward
            p_col_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !a[i] |-> !c_row[r][i]);
        end
    end

    logic [CELLS-1:0] rx;
    logic [CELLS-1:0] rsum;
    logic             rcout;

    for (genvar j = 0; j < CELLS; j++) begin : g_rin
        if (j < CELLS - 1) begin : g_s
            assign rx[j] = s_row[ROWS][j+1];
        end else begin : g_top
            assign rx[j] = a[N-1] & b[N-1];
        end
    end

    cbm_ripple #(.W(CELLS)) u_ripple (
        .x    (rx),
        .y    (c_row[ROWS]),
        .sum  (rsum),
        .cout (rcout)
    );

    assign prod[0] = a[0] & b[0];
    for (genvar r = 1; r <= ROWS; r++) begin : g_low
        assign prod[r] = s_row[r][0];
    end
    assign prod[2*N-2:N] = rsum;
    assign prod[2*N-1]   = rcout;

endmodule

// File: rtl/col_bypass_mult.sv
module col_bypass_mult #(
    parameter int N       = 4,
    parameter bit IN_REG  = 1'b0,
    parameter bit OUT_REG = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product
);

    localparam int PW = 2 * N;

    logic [PW-1:0] ops_q;
    logic [N-1:0]  op_a, op_b;
    logic [PW-1:0] arr_prod;

    cbm_stage #(.W(PW), .EN(IN_REG)) u_in_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mcand, mplier}),
        .q     (ops_q)
    );

    assign op_a = ops_q[PW-1:N];
    assign op_b = ops_q[N-1:0];

    cbm_array #(.N(N)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (op_a),
        .b     (op_b),
        .prod  (arr_prod)
    );

    cbm_stage #(.W(PW), .EN(OUT_REG)) u_out_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (arr_prod),
        .q     (product)
    );

    // R1: grid output matches the arithmetic product
    p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prod == (PW'(op_a) * PW'(op_b)));

    // R2: zero multiplicand yields zero
    p_zero_mcand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_a == '0) |-> (arr_prod == '0));

    // R5: unit multiplicator passes the multiplicand
    p_unit_mplier_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_b == N'(1)) |-> (arr_prod == PW'(op_a)));

endmodule

// File: tb/sim_col_bypass_mult.sv
`timescale 1ns/1ps
module sim_col_bypass_mult;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    col_bypass_mult #(.N(4), .IN_REG(1'b1), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .mcand(a4), .mplier(b4), .product(p4));

    col_bypass_mult #(.N(8), .IN_REG(1'b0), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .mcand(a8), .mplier(b8), .product(p8));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive u0 on a falling edge, sample two falling edges later
    task automatic run4(input logic [3:0] x, input logic [3:0] y, output logic [7:0] got);
        @(negedge clk);
        a4 = x; b4 = y;
        @(negedge clk);
        @(negedge clk);
        got = p4;
    endtask

    task automatic run8(input logic [7:0] x, input logic [7:0] y, output logic [15:0] got);
        @(negedge clk);
        a8 = x; b8 = y;
        #1;
        got = p8;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        a4 = 4'hF; b4 = 4'hF;
        repeat (3) @(negedge clk);
        check("R8 reset clears product", 64'(p4), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_exhaustive;
        logic [7:0] g;
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                run4(4'(x), 4'(y), g);
                check("R1 exhaustive", 64'(g), 64'(x * y));
            end
        end
    endtask

    task automatic t_zero_and_unit;
        logic [7:0] g;
        run4(4'd0, 4'd13, g);  check("R2 zero multiplicand", 64'(g), 64'd0);
        run4(4'b1010, 4'b1111, g); check("R2 interleaved zeros", 64'(g), 64'd150);
        run4(4'd9, 4'd0, g);   check("R5 zero multiplicator", 64'(g), 64'd0);
        run4(4'd11, 4'd1, g);  check("R5 unit multiplicator", 64'(g), 64'd11);
    endtask

    task automatic t_max;
        logic [7:0]  g;
        logic [15:0] h;
        run4(4'hF, 4'hF, g);   check("R3 max N=4", 64'(g), 64'd225);
        run8(8'hFF, 8'hFF, h); check("R3 max N=8", 64'(h), 64'd65025);
    endtask

    task automatic t_one_hot;
        logic [7:0]  g;
        logic [15:0] h;
        for (int k = 0; k < 4; k++) begin
            run4(4'(1 << k), 4'hF, g);
            check("R4 one-hot column N=4", 64'(g), 64'(15 << k));
        end
        for (int k = 0; k < 8; k++) begin
            run8(8'(1 << k), 8'hB7, h);
            check("R4 one-hot column N=8", 64'(h), 64'(183 << k));
        end
    endtask

    task automatic t_latency;
        logic [7:0] g;
        run4(4'd3, 4'd5, g);
        check("R6 settled first", 64'(g), 64'd15);
        a4 = 4'd7; b4 = 4'd9;
        @(negedge clk);
        check("R6 old product after one edge", 64'(p4), 64'd15);
        @(negedge clk);
        check("R6 new product after two edges", 64'(p4), 64'd63);
    endtask

    task automatic t_wide;
        logic [15:0] h;
        logic [7:0]  x, y;
        run8(8'd0, 8'd77, h);  check("R7 comb zero", 64'(h), 64'd0);
        run8(8'd200, 8'd1, h); check("R7 comb unit", 64'(h), 64'd200);
        run8(8'hAA, 8'h55, h); check("R9 pattern", 64'(h), 64'(170 * 85));
        for (int n = 0; n < 300; n++) begin
            x = 8'($urandom());
            y = 8'($urandom());
            run8(x, y, h);
            check("R9 random", 64'(h), 64'(32'(x) * 32'(y)));
        end
    endtask

    initial begin
        void'($urandom(32'd12345));
        t_reset();
        t_exhaustive();
        t_zero_and_unit();
        t_max();
        t_one_hot();
        t_latency();
        t_wide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule